// File: doc/BRIEF.md
# PCI Legacy Interrupt Router

This block gathers three kinds of level-sensitive interrupt wires into one flat space of 48 global system interrupt (GSI) lines. The three kinds are the 128 PCI INTx wires (32 devices with four pins each), the 16 ISA IRQ wires and a single callback wire. A downstream interrupt controller receives two vectors: the level of every GSI, and a one-cycle pulse on any GSI whose contributor count has just risen from zero.

Each PCI wire feeds two paths at the same time. The first is a direct hashed GSI in the range 16 to 47. The second is one of four shared links. Each link has a route register that steers it onto a GSI in the ISA range. Several wires can share a GSI, so each GSI is resolved by counting its asserted contributors, not by a plain OR. A line therefore stays high while at least one contributor still drives it. Each wire has a state bit, and a repeated request does not disturb any count. If a route is rewritten while its link is active, the link's contribution moves to the new GSI in the same clock.

Top module: `pci_intx_router`

## Requirements
- R1: After reset, every wire state is clear, every route and the callback GSI are 0 (disabled), and `gsi_level` and `gsi_edge` are all zero.
- R2: A request with `req_kind`=1 sets or clears ISA wire `req_isa`. That wire drives GSI number `req_isa` (0 to 15).
- R3: A request with `req_kind`=0 sets or clears PCI wire (`req_dev`, `req_pin`). That wire drives the GSI ((`req_dev`*4 + `req_dev`/8 + `req_pin`) mod 32) + 16.
- R4: The same PCI wire also joins link (`req_dev` + `req_pin`) mod 4. A write with `cfg_we`=1 and `cfg_sel`=0..3 loads that link's route from `cfg_data[3:0]`. An active link drives the GSI equal to its route, and route 0 disables it.
- R5: A GSI level is high while any of its contributors is asserted: its ISA wire, a direct PCI wire, an active routed link or the callback. It falls only when the last contributor is removed.
- R6: A request to assert a wire that is already asserted, or to deassert one that is already clear, has no effect on any output. `req_kind`=3 is ignored.
- R7: In the clock after a GSI count rises from zero, `gsi_edge` for that GSI is high for exactly one cycle. No pulse is produced while the count was already non-zero.
- R8: If a route is rewritten while its link is active, the old GSI loses the link's contribution and the new GSI gains it at the same edge. The new GSI pulses if its count rose from zero.
- R9: A request with `req_kind`=2 sets or clears the callback wire. A write with `cfg_sel`=4 loads the callback GSI from `cfg_data`. Values 1 to 47 select a GSI, and 0 disables the callback.
- R10: Link and GSI counters never wrap in either direction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Wire request present this cycle |
| req_kind | input | 2 | 0 PCI, 1 ISA, 2 callback, 3 none |
| req_level | input | 1 | 1 assert, 0 deassert |
| req_dev | input | 5 | PCI device number |
| req_pin | input | 2 | PCI INTx pin (0..3) |
| req_isa | input | 4 | ISA IRQ number |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | 0..3 link route, 4 callback GSI |
| cfg_data | input | 6 | Value written |
| gsi_level | output | 48 | Level of each GSI |
| gsi_edge | output | 48 | One-cycle rising pulse per GSI |

## Verification
The bench targets a route rewritten while its link is active. A design that moves the contribution late, or not at all, leaves the old GSI stuck high and the new one dark. It also repeats asserts and deasserts: a design without per-wire state would double-count the wire and keep a line high after its real release. Wire-OR release through a shared link is tested, where a plain OR in place of counting drops the line too early. Callback disable through GSI 0 is also tested. Random traffic mixed with route writes compares the level vector and the edge pulses against a model recomputed from scratch after every request.

// File: rtl/router_pkg.sv
package router_pkg;
   localparam int PCI_DEVS  = 32;
   localparam int PCI_PINS  = 4;
   localparam int PCI_WIRES = PCI_DEVS * PCI_PINS;
   localparam int LINKS     = 4;
   localparam int ISA_IRQS  = 16;
   localparam int DIRECT_BASE = 16;
   localparam int GSIS      = 48;
   localparam int GSI_W     = $clog2(GSIS);
   localparam int ROUTE_W   = $clog2(ISA_IRQS);
   localparam int DEV_W     = $clog2(PCI_DEVS);
   localparam int PIN_W     = $clog2(PCI_PINS);
   localparam int SEL_CB    = LINKS;

   typedef enum logic [1:0] {
      REQ_PCI  = 2'd0,
      REQ_ISA  = 2'd1,
      REQ_CB   = 2'd2,
      REQ_NONE = 2'd3
   } req_kind_e;

   function automatic logic [PIN_W-1:0] link_of(input logic [DEV_W-1:0] dev,
                                                input logic [PIN_W-1:0] pin);
      return dev[PIN_W-1:0] + pin;
   endfunction

   function automatic logic [GSI_W-1:0] direct_gsi_of(input logic [DEV_W-1:0] dev,
                                                      input logic [PIN_W-1:0] pin);
      logic [4:0] h;
      h = {dev[2:0], 2'b00} + {3'b000, dev[4:3]} + {3'b000, pin};
      return {1'b0, h} + GSI_W'(DIRECT_BASE);
   endfunction
endpackage

// File: rtl/wire_tracker.sv
module wire_tracker
   import router_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  req_kind_e        req_kind,
   input  logic             req_level,
   input  logic [DEV_W-1:0] req_dev,
   input  logic [PIN_W-1:0] req_pin,
   input  logic [3:0]       req_isa,
   output logic             evt_pci,
   output logic             evt_isa,
   output logic             evt_cb,
   output logic             cb_on_q,
   output logic             cb_on_d
);
   localparam int WIDX_W = DEV_W + PIN_W;

   logic [PCI_WIRES-1:0] pci_st;
   logic [ISA_IRQS-1:0]  isa_st;
   logic                 cb_st;
   logic [WIDX_W-1:0]    widx;

   always_comb begin
      widx    = {req_dev, req_pin};
      evt_pci = req_valid && (req_kind == REQ_PCI) && (pci_st[widx] != req_level);
      evt_isa = req_valid && (req_kind == REQ_ISA) && (isa_st[req_isa] != req_level);
      evt_cb  = req_valid && (req_kind == REQ_CB)  && (cb_st != req_level);
      cb_on_q = cb_st;
      cb_on_d = evt_cb ? req_level : cb_st;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pci_st <= '0;
         isa_st <= '0;
         cb_st  <= 1'b0;
      end else begin
         if (evt_pci) pci_st[widx]    <= req_level;
         if (evt_isa) isa_st[req_isa] <= req_level;
         cb_st <= cb_on_d;
      end
   end

   assert_one_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({evt_pci, evt_isa, evt_cb}));
endmodule

// File: rtl/link_bank.sv
module link_bank
   import router_pkg::*;
#(
   parameter int CNT_W = 8
)(
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            evt_pci,
   input  logic                            evt_up,
   input  logic [DEV_W-1:0]                req_dev,
   input  logic [PIN_W-1:0]                req_pin,
   input  logic                            cfg_we,
   input  logic [2:0]                      cfg_sel,
   input  logic [ROUTE_W-1:0]              cfg_route,
   output logic [LINKS-1:0]                act_q,
   output logic [LINKS-1:0]                act_d,
   output logic [LINKS-1:0][ROUTE_W-1:0]   route_q,
   output logic [LINKS-1:0][ROUTE_W-1:0]   route_d
);
   for (genvar l = 0; l < LINKS; l++) begin : g_link
      logic [CNT_W-1:0] cnt, cnt_d;
      logic             hit;

      always_comb begin
         hit   = evt_pci && (link_of(req_dev, req_pin) == PIN_W'(l));
         cnt_d = cnt;
         if (hit) cnt_d = evt_up ? cnt + 1'b1 : cnt - 1'b1;
         act_q[l]   = (cnt != '0);
         act_d[l]   = (cnt_d != '0);
         route_d[l] = (cfg_we && cfg_sel == 3'(l)) ? cfg_route : route_q[l];
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cnt        <= '0;
            route_q[l] <= '0;
         end else begin
            cnt        <= cnt_d;
            route_q[l] <= route_d[l];
         end
      end

      assert_link_no_underflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
         (hit && !evt_up) |-> (cnt != '0));
      assert_link_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
         (hit && evt_up) |-> (cnt != '1));
   end
endmodule

// File: rtl/gsi_cell.sv
module gsi_cell #(
   parameter int CNT_W = 4,
   parameter int DELTA_W = 3
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [DELTA_W-1:0] add,
   input  logic [DELTA_W-1:0] sub,
   output logic               level,
   output logic               edge_q
);
   logic [CNT_W:0]   sum;
   logic [CNT_W-1:0] cnt, cnt_d;

   always_comb begin
      sum   = {1'b0, cnt} + (CNT_W+1)'(add) - (CNT_W+1)'(sub);
      cnt_d = sum[CNT_W-1:0];
      level = (cnt != '0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt    <= '0;
         edge_q <= 1'b0;
      end else begin
         cnt    <= cnt_d;
         edge_q <= (cnt == '0) && (cnt_d != '0);
      end
   end

   assert_no_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, cnt} + (CNT_W+1)'(add)) >= (CNT_W+1)'(sub));
   assert_edge_from_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      edge_q |-> (level && $past(cnt) == '0));
endmodule

// File: rtl/pci_intx_router.sv
module pci_intx_router
   import router_pkg::*;
#(
   parameter int LINK_CNT_W = 8,
   parameter int GSI_CNT_W  = 4
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req_valid,
   input  logic [1:0]  req_kind,
   input  logic        req_level,
   input  logic [4:0]  req_dev,
   input  logic [1:0]  req_pin,
   input  logic [3:0]  req_isa,
   input  logic        cfg_we,
   input  logic [2:0]  cfg_sel,
   input  logic [5:0]  cfg_data,
   output logic [47:0] gsi_level,
   output logic [47:0] gsi_edge
);
   localparam int DELTA_W = 3;
   localparam int MAX_GSI_SHARE = PCI_PINS + LINKS + 2;

   if ((1 << LINK_CNT_W) <= PCI_DEVS) begin : g_bad_link_w
      $error("LINK_CNT_W too small for full link sharing");
   end
   if ((1 << GSI_CNT_W) <= MAX_GSI_SHARE) begin : g_bad_gsi_w
      $error("GSI_CNT_W too small for worst-case GSI sharing");
   end

   logic evt_pci, evt_isa, evt_cb, cb_on_q, cb_on_d;
   logic [LINKS-1:0] act_q, act_d;
   logic [LINKS-1:0][ROUTE_W-1:0] route_q, route_d;
   logic [GSI_W-1:0] cb_gsi_q, cb_gsi_d, dgsi;
   logic [GSIS-1:0][DELTA_W-1:0] add, sub;

   wire_tracker i_track (
      .clk, .rst_n, .req_valid,
      .req_kind(req_kind_e'(req_kind)),
      .req_level, .req_dev, .req_pin, .req_isa,
      .evt_pci, .evt_isa, .evt_cb, .cb_on_q, .cb_on_d
   );

   link_bank #(.CNT_W(LINK_CNT_W)) i_links (
      .clk, .rst_n, .evt_pci, .evt_up(req_level), .req_dev, .req_pin,
      .cfg_we, .cfg_sel, .cfg_route(cfg_data[ROUTE_W-1:0]),
      .act_q, .act_d, .route_q, .route_d
   );

   always_comb begin
      cb_gsi_d = (cfg_we && cfg_sel == 3'(SEL_CB)) ? cfg_data : cb_gsi_q;
      dgsi     = direct_gsi_of(req_dev, req_pin);
      for (int g = 0; g < GSIS; g++) begin
         add[g] = '0;
         sub[g] = '0;
         if (g != 0) begin
            for (int l = 0; l < LINKS; l++) begin
               if (act_d[l] && GSI_W'(route_d[l]) == GSI_W'(g)) add[g] = add[g] + 1'b1;
               if (act_q[l] && GSI_W'(route_q[l]) == GSI_W'(g)) sub[g] = sub[g] + 1'b1;
            end
            if (cb_on_d && cb_gsi_d == GSI_W'(g)) add[g] = add[g] + 1'b1;
            if (cb_on_q && cb_gsi_q == GSI_W'(g)) sub[g] = sub[g] + 1'b1;
         end
         if ((evt_isa && GSI_W'(req_isa) == GSI_W'(g)) || (evt_pci && dgsi == GSI_W'(g))) begin
            if (req_level) add[g] = add[g] + 1'b1;
            else           sub[g] = sub[g] + 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cb_gsi_q <= '0;
      else        cb_gsi_q <= cb_gsi_d;
   end

   for (genvar g = 0; g < GSIS; g++) begin : g_gsi
      gsi_cell #(.CNT_W(GSI_CNT_W), .DELTA_W(DELTA_W)) i_cell (
         .clk, .rst_n, .add(add[g]), .sub(sub[g]),
         .level(gsi_level[g]), .edge_q(gsi_edge[g])
      );
   end

   assert_route_move_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q[0] && act_d[0] && route_q[0] != route_d[0] && route_d[0] != '0)
      |=> gsi_level[GSI_W'(route_q[0])]);
endmodule

// File: tb/test_pci_intx_router.sv
module test_pci_intx_router;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_kind = 2'd3;
   logic        req_level = 1'b0;
   logic [4:0]  req_dev = '0;
   logic [1:0]  req_pin = '0;
   logic [3:0]  req_isa = '0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_sel = '0;
   logic [5:0]  cfg_data = '0;
   logic [47:0] gsi_level, gsi_edge;

   int checks = 0;
   int errors = 0;

   bit [127:0] m_pci;
   bit [15:0]  m_isa;
   bit         m_cb;
   bit [3:0]   m_route [4];
   bit [5:0]   m_cbg;
   bit [47:0]  m_prev;

   always #5 clk = ~clk;

   pci_intx_router i_pci_intx_router (
      .clk, .rst_n, .req_valid, .req_kind, .req_level, .req_dev, .req_pin,
      .req_isa, .cfg_we, .cfg_sel, .cfg_data, .gsi_level, .gsi_edge
   );

   function automatic bit [47:0] calc_level();
      bit [47:0] v = '0;
      for (int g = 0; g < 16; g++) if (m_isa[g]) v[g] = 1'b1;
      for (int w = 0; w < 128; w++) begin
         if (m_pci[w]) begin
            int dev = w / 4;
            int pin = w % 4;
            int dg  = ((dev * 4 + dev / 8 + pin) % 32) + 16;
            int lk  = (dev + pin) % 4;
            v[dg] = 1'b1;
            if (m_route[lk] != 0) v[m_route[lk]] = 1'b1;
         end
      end
      if (m_cb && m_cbg != 0 && m_cbg < 48) v[m_cbg] = 1'b1;
      return v;
   endfunction

   task automatic check(input string tag, input bit [47:0] got, input bit [47:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %h exp %h", tag, got, exp);
      end
   endtask

   task automatic op(input bit v, input bit [1:0] k, input bit lv, input bit [4:0] d,
                     input bit [1:0] p, input bit [3:0] irq, input bit we,
                     input bit [2:0] sel, input bit [5:0] data, input string tag);
      bit [47:0] exp;
      @(negedge clk);
      req_valid = v; req_kind = k; req_level = lv; req_dev = d; req_pin = p;
      req_isa = irq; cfg_we = we; cfg_sel = sel; cfg_data = data;
      if (we && sel < 4) m_route[sel] = data[3:0];
      if (we && sel == 4) m_cbg = data;
      if (v) begin
         case (k)
            2'd0: m_pci[d * 4 + p] = lv;
            2'd1: m_isa[irq] = lv;
            2'd2: m_cb = lv;
            default: ;
         endcase
      end
      @(negedge clk);
      req_valid = 1'b0; cfg_we = 1'b0;
      exp = calc_level();
      check({tag, " level"}, gsi_level, exp);
      check({tag, " edge"}, gsi_edge, exp & ~m_prev);
      m_prev = exp;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      m_pci = '0; m_isa = '0; m_cb = 0; m_cbg = 0; m_prev = '0;
      for (int i = 0; i < 4; i++) m_route[i] = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset level", gsi_level, '0);
      check("R1 reset edge", gsi_edge, '0);

      op(1, 1, 1, 0, 0, 5, 0, 0, 0, "R2 isa5 on");
      op(1, 1, 1, 0, 0, 5, 0, 0, 0, "R6 isa5 repeat on");
      op(1, 1, 0, 0, 0, 5, 0, 0, 0, "R2 isa5 off");
      op(1, 1, 0, 0, 0, 5, 0, 0, 0, "R6 isa5 repeat off");
      op(1, 3, 1, 0, 0, 7, 0, 0, 0, "R6 kind3 ignored");
      op(1, 0, 1, 9, 2, 0, 0, 0, 0, "R3 dev9 pin2 direct 23");
      op(0, 0, 0, 0, 0, 0, 1, 3, 11, "R8 R4 route link3 to 11 while active");
      op(1, 0, 1, 1, 2, 0, 0, 0, 0, "R5 second wire on link3");
      op(1, 0, 0, 9, 2, 0, 0, 0, 0, "R5 link3 still shared");
      op(0, 0, 0, 0, 0, 0, 1, 3, 12, "R8 move link3 to 12");
      op(1, 1, 1, 0, 0, 12, 0, 0, 0, "R7 isa12 joins no edge");
      op(1, 0, 0, 1, 2, 0, 0, 0, 0, "R5 link3 release");
      op(0, 0, 0, 0, 0, 0, 1, 3, 0, "R4 route 0 disables");
      op(0, 0, 0, 0, 0, 0, 1, 4, 30, "R9 callback gsi 30");
      op(1, 2, 1, 0, 0, 0, 0, 0, 0, "R9 callback on");
      op(1, 2, 1, 0, 0, 0, 1, 4, 0, "R9 callback disabled via 0");
      op(1, 2, 0, 0, 0, 0, 1, 4, 40, "R9 callback off");

      void'($urandom(32'h5eed_1234));
      for (int n = 0; n < 3000; n++) begin
         bit [1:0] k   = 2'($urandom_range(0, 3));
         bit       we  = ($urandom_range(0, 7) == 0);
         bit [2:0] sel = 3'($urandom_range(0, 4));
         bit [5:0] dat = (sel == 4) ? 6'($urandom_range(0, 47)) : 6'($urandom_range(0, 15));
         op(1, k, 1'($urandom), 5'($urandom), 2'($urandom), 4'($urandom),
            we, sel, dat, "R5 R7 R8 R10 random");
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule